// File: doc/BRIEF.md
# Composite Sync Generator for 625-line and 525-line Video

This block produces free-running video synchronisation from a fixed tick clock. It counts ticks inside half-line slots and half-line slots inside a frame, and from those two counts it derives an active-low composite sync, an active-low horizontal sync, an active-low vertical sync, a field flag and the current frame line number. One input picks 625-line (PAL-style) or 525-line (NTSC-style) timing. A second input picks interlaced fields, which differ by half a line, or non-interlaced fields, which all have the same whole number of lines.

Each field opens with a vertical interval of fifteen half-line slots. The first five and the last five carry narrow equalizing pulses and the middle five carry wide broad pulses. Outside that interval, the composite output carries a line-sync pulse at the start of each line. Every pulse width is a tick-count parameter. The defaults assume a 50 ns tick. While the enable is low, the generator is idle and drives all syncs inactive. A change of standard or interlace mode is applied only when a frame ends.

Top module: `csync_gen`

## Requirements
- R1: While `en` is low and after reset, `csync_n`, `hsync_n` and `vsync_n` are 1, `field_id` is 0 and `line_num` is 0. After `en` is first sampled high, tick 0 of the frame appears on the outputs two clock edges later.
- R2: A line is two half-line slots. Each slot lasts `PAL_HALF` or `NTSC_HALF` ticks, which is 640 or 636 by default. Outside the vertical interval, `csync_n` is low for the first `*_LSYNC` ticks (94 by default) of a slot that starts a line, and is high at all other times.
- R3: In interlaced mode a field is `PAL_LINES` (625) or `NTSC_LINES` (525) half-line slots long, so the second field starts in the middle of line 313 or line 263. In non-interlaced mode a field is 624 or 524 slots (312 or 262 whole lines). A frame is always two fields.
- R4: Field-relative slots 0 to 4 and 10 to 14 are equalizing slots, with `csync_n` low for the first `*_EQ` ticks. Slots 5 to 9 are broad slots, with `csync_n` low for the first `*_BROAD` ticks and high for the rest of the slot (the serration).
- R5: `hsync_n` is low for the first `HS_W` ticks of every line, including lines inside the vertical interval. `HS_W` is 40 by default, about 2 µs.
- R6: `vsync_n` is low during the first two half-line slots of every field, which is one line.
- R7: `field_id` is 0 during the first field of a frame and 1 during the second.
- R8: `line_num` gives the frame line starting from 1, equal to slot index / 2 + 1, so it runs 1 to 625 (or 525) when interlaced and 1 to 624 (or 524) when not.
- R9: `std_ntsc` = 0 selects the 625-line constants and `std_ntsc` = 1 selects the 525-line constants. `interlace` = 1 selects interlaced fields.
- R10: A change of `std_ntsc` or `interlace` during a frame has no effect until the first tick of the next frame. While `en` is low, the inputs are taken directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low holds the generator idle at frame start |
| std_ntsc | input | 1 | 0 = 625-line timing, 1 = 525-line timing |
| interlace | input | 1 | 1 = interlaced fields, 0 = non-interlaced |
| csync_n | output | 1 | Composite sync, active low |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low, one line per field |
| field_id | output | 1 | 0 in the first field, 1 in the second |
| line_num | output | LW (10) | Frame line number starting from 1; 0 when idle |

## Verification
The bound checker examines a set of properties on every cycle:
- Idle outputs after the enable drops.
- `line_num` stays in range and steps by one or wraps to 1.
- Every falling edge of `hsync_n` and `vsync_n` coincides with a low composite sync.
- The field flag changes only together with the start of a vertical sync.

The exact shape of each pulse cannot be expressed as a simple property. This covers the equalizing versus broad widths, the mid-line start of the second interlaced field, the field lengths of each standard, and the deferral of a mode change to the frame boundary. The bench shows these by comparing every output on every tick of four consecutive frames, one in each standard and interlace combination, against values it computes arithmetically from the tick count.

// File: rtl/csync_pkg.sv
package csync_pkg;

    typedef enum logic [1:0] {
        SLOT_PLAIN = 2'd0,
        SLOT_EQ    = 2'd1,
        SLOT_BROAD = 2'd2
    } slot_kind_e;

endpackage

// File: rtl/csync_std_sel.sv
// Picks the per-standard tick and slot constants for the active configuration.
module csync_std_sel #(
    parameter int PAL_HALF    = 640,
    parameter int PAL_LSYNC   = 94,
    parameter int PAL_EQ      = 47,
    parameter int PAL_BROAD   = 546,
    parameter int NTSC_HALF   = 636,
    parameter int NTSC_LSYNC  = 94,
    parameter int NTSC_EQ     = 46,
    parameter int NTSC_BROAD  = 542,
    parameter int PAL_LINES   = 625,
    parameter int NTSC_LINES  = 525,
    parameter int TW          = 10,
    parameter int HW          = 11
) (
    input  logic          ntsc,
    input  logic          ilace,
    output logic [TW-1:0] half_last,
    output logic [TW-1:0] lsync_w,
    output logic [TW-1:0] eq_w,
    output logic [TW-1:0] broad_w,
    output logic [HW-1:0] field_len,
    output logic [HW-1:0] frame_last
);

    localparam logic [TW-1:0] P_HL = TW'(PAL_HALF - 1);
    localparam logic [TW-1:0] N_HL = TW'(NTSC_HALF - 1);
    localparam logic [TW-1:0] P_LS = TW'(PAL_LSYNC);
    localparam logic [TW-1:0] N_LS = TW'(NTSC_LSYNC);
    localparam logic [TW-1:0] P_EQW = TW'(PAL_EQ);
    localparam logic [TW-1:0] N_EQW = TW'(NTSC_EQ);
    localparam logic [TW-1:0] P_BRW = TW'(PAL_BROAD);
    localparam logic [TW-1:0] N_BRW = TW'(NTSC_BROAD);
    // interlaced fields are an odd count of half-lines, progressive ones even
    localparam logic [HW-1:0] P_FLD_I = HW'(PAL_LINES);
    localparam logic [HW-1:0] P_FLD_P = HW'(PAL_LINES - 1);
    localparam logic [HW-1:0] N_FLD_I = HW'(NTSC_LINES);
    localparam logic [HW-1:0] N_FLD_P = HW'(NTSC_LINES - 1);

    always_comb begin
        half_last = ntsc ? N_HL  : P_HL;
        lsync_w   = ntsc ? N_LS  : P_LS;
        eq_w      = ntsc ? N_EQW : P_EQW;
        broad_w   = ntsc ? N_BRW : P_BRW;
        if (ntsc) begin
            field_len = ilace ? N_FLD_I : N_FLD_P;
        end else begin
            field_len = ilace ? P_FLD_I : P_FLD_P;
        end
        frame_last = (field_len << 1) - HW'(1);
    end

endmodule

// File: rtl/csync_slot_dec.sv
// Classifies a frame half-line slot: field, line start, vertical slot kind.
module csync_slot_dec
    import csync_pkg::*;
#(
    parameter int HW          = 11,
    parameter int EQ_SLOTS    = 5,
    parameter int BROAD_SLOTS = 5,
    parameter int VS_SLOTS    = 2
) (
    input  logic [HW-1:0] hc,
    input  logic [HW-1:0] field_len,
    output logic          fld,
    output logic          line_start,
    output logic          vs_slot,
    output slot_kind_e    kind
);

    localparam logic [HW-1:0] BROAD_LO = HW'(EQ_SLOTS);
    localparam logic [HW-1:0] BROAD_HI = HW'(EQ_SLOTS + BROAD_SLOTS);
    localparam logic [HW-1:0] VI_END   = HW'(2 * EQ_SLOTS + BROAD_SLOTS);
    localparam logic [HW-1:0] VS_END   = HW'(VS_SLOTS);

    logic [HW-1:0] h_rel;

    always_comb begin
        fld        = (hc >= field_len);
        h_rel      = fld ? (hc - field_len) : hc;
        line_start = ~hc[0];
        vs_slot    = (h_rel < VS_END);
        if (h_rel < BROAD_LO) begin
            kind = SLOT_EQ;
        end else if (h_rel < BROAD_HI) begin
            kind = SLOT_BROAD;
        end else if (h_rel < VI_END) begin
            kind = SLOT_EQ;
        end else begin
            kind = SLOT_PLAIN;
        end
    end

endmodule

// File: rtl/csync_pulse_shape.sv
// Turns slot kind and tick position into composite and horizontal pulse levels.
module csync_pulse_shape
    import csync_pkg::*;
#(
    parameter int TW   = 10,
    parameter int HS_W = 40
) (
    input  slot_kind_e    kind,
    input  logic          line_start,
    input  logic [TW-1:0] tk,
    input  logic [TW-1:0] lsync_w,
    input  logic [TW-1:0] eq_w,
    input  logic [TW-1:0] broad_w,
    output logic          cs_low,
    output logic          hs_low
);

    localparam logic [TW-1:0] HS_LEN = TW'(HS_W);

    always_comb begin
        case (kind)
            SLOT_EQ:    cs_low = (tk < eq_w);
            SLOT_BROAD: cs_low = (tk < broad_w);
            default:    cs_low = line_start && (tk < lsync_w);
        endcase
        hs_low = line_start && (tk < HS_LEN);
    end

endmodule

// File: rtl/csync_gen.sv
module csync_gen
    import csync_pkg::*;
#(
    parameter int PAL_HALF    = 640,
    parameter int PAL_LSYNC   = 94,
    parameter int PAL_EQ      = 47,
    parameter int PAL_BROAD   = 546,
    parameter int NTSC_HALF   = 636,
    parameter int NTSC_LSYNC  = 94,
    parameter int NTSC_EQ     = 46,
    parameter int NTSC_BROAD  = 542,
    parameter int HS_W        = 40,
    parameter int PAL_LINES   = 625,
    parameter int NTSC_LINES  = 525,
    parameter int EQ_SLOTS    = 5,
    parameter int BROAD_SLOTS = 5,
    parameter int VS_SLOTS    = 2,
    localparam int MAX_HALF   = (PAL_HALF > NTSC_HALF) ? PAL_HALF : NTSC_HALF,
    localparam int MAX_LINES  = (PAL_LINES > NTSC_LINES) ? PAL_LINES : NTSC_LINES,
    localparam int TW         = $clog2(MAX_HALF + 1),
    localparam int HW         = $clog2(2 * MAX_LINES + 1),
    localparam int LW         = $clog2(MAX_LINES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          std_ntsc,
    input  logic          interlace,
    output logic          csync_n,
    output logic          hsync_n,
    output logic          vsync_n,
    output logic          field_id,
    output logic [LW-1:0] line_num
);

    typedef struct packed {
        logic          run;
        logic          ntsc;
        logic          ilace;
        logic [HW-1:0] hc;
        logic [TW-1:0] tk;
        logic          cs_n;
        logic          hs_n;
        logic          vs_n;
        logic          fld;
        logic [LW-1:0] line;
    } gen_state_t;

    localparam gen_state_t ST_RESET = '{
        run: 1'b0, ntsc: 1'b0, ilace: 1'b0, hc: '0, tk: '0,
        cs_n: 1'b1, hs_n: 1'b1, vs_n: 1'b1, fld: 1'b0, line: '0
    };

    gen_state_t st_d, st_q;

    logic [TW-1:0] half_last, lsync_w, eq_w, broad_w;
    logic [HW-1:0] field_len, frame_last;
    logic          fld_now, line_start, vs_slot, cs_low, hs_low;
    slot_kind_e    kind;

    csync_std_sel #(
        .PAL_HALF(PAL_HALF), .PAL_LSYNC(PAL_LSYNC), .PAL_EQ(PAL_EQ), .PAL_BROAD(PAL_BROAD),
        .NTSC_HALF(NTSC_HALF), .NTSC_LSYNC(NTSC_LSYNC), .NTSC_EQ(NTSC_EQ),
        .NTSC_BROAD(NTSC_BROAD), .PAL_LINES(PAL_LINES), .NTSC_LINES(NTSC_LINES),
        .TW(TW), .HW(HW)
    ) u_std (
        .ntsc       (st_q.ntsc),
        .ilace      (st_q.ilace),
        .half_last  (half_last),
        .lsync_w    (lsync_w),
        .eq_w       (eq_w),
        .broad_w    (broad_w),
        .field_len  (field_len),
        .frame_last (frame_last)
    );

    csync_slot_dec #(
        .HW(HW), .EQ_SLOTS(EQ_SLOTS), .BROAD_SLOTS(BROAD_SLOTS), .VS_SLOTS(VS_SLOTS)
    ) u_slot (
        .hc         (st_q.hc),
        .field_len  (field_len),
        .fld        (fld_now),
        .line_start (line_start),
        .vs_slot    (vs_slot),
        .kind       (kind)
    );

    csync_pulse_shape #(
        .TW(TW), .HS_W(HS_W)
    ) u_pulse (
        .kind       (kind),
        .line_start (line_start),
        .tk         (st_q.tk),
        .lsync_w    (lsync_w),
        .eq_w       (eq_w),
        .broad_w    (broad_w),
        .cs_low     (cs_low),
        .hs_low     (hs_low)
    );

    always_comb begin
        st_d = st_q;

        // outputs reflect the tick held in the counters this cycle
        if (st_q.run) begin
            st_d.cs_n = ~cs_low;
            st_d.hs_n = ~hs_low;
            st_d.vs_n = ~vs_slot;
            st_d.fld  = fld_now;
            st_d.line = LW'(st_q.hc[HW-1:1]) + LW'(1);
        end else begin
            st_d.cs_n = 1'b1;
            st_d.hs_n = 1'b1;
            st_d.vs_n = 1'b1;
            st_d.fld  = 1'b0;
            st_d.line = '0;
        end

        // tick and half-line counters; configuration latched at frame start
        if (!en) begin
            st_d.run   = 1'b0;
            st_d.hc    = '0;
            st_d.tk    = '0;
            st_d.ntsc  = std_ntsc;
            st_d.ilace = interlace;
        end else begin
            st_d.run = 1'b1;
            if (st_q.run) begin
                if (st_q.tk == half_last) begin
                    st_d.tk = '0;
                    if (st_q.hc == frame_last) begin
                        st_d.hc    = '0;
                        st_d.ntsc  = std_ntsc;
                        st_d.ilace = interlace;
                    end else begin
                        st_d.hc = st_q.hc + HW'(1);
                    end
                end else begin
                    st_d.tk = st_q.tk + TW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign csync_n  = st_q.cs_n;
    assign hsync_n  = st_q.hs_n;
    assign vsync_n  = st_q.vs_n;
    assign field_id = st_q.fld;
    assign line_num = st_q.line;

endmodule

// File: rtl/csync_gen_chk.sv
module csync_gen_chk #(
    parameter int LW        = 10,
    parameter int MAX_LINES = 625
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          csync_n,
    input logic          hsync_n,
    input logic          vsync_n,
    input logic          field_id,
    input logic [LW-1:0] line_num
);

    localparam logic [LW-1:0] LINE_MAX = LW'(MAX_LINES);

    // R1: two edges after a low enable, every output is idle
    assert_idle_outputs_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ##1 (csync_n && hsync_n && vsync_n && !field_id && line_num == '0));

    // R8: line number never exceeds the longest frame
    assert_line_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        line_num <= LINE_MAX);

    // R8: a running line number advances by one or wraps to line 1
    assert_line_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (line_num != $past(line_num) && line_num != '0 && $past(line_num) != '0)
        |-> (line_num == $past(line_num) + LW'(1) || line_num == LW'(1)));

    // R5: a horizontal pulse starts only where the composite output is low
    assert_hs_in_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hsync_n) |-> !csync_n);

    // R6: vertical sync starts together with a composite pulse
    assert_vs_in_cs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vsync_n) |-> !csync_n);

    // R7: while running, the field flag flips only at the start of a vertical sync
    assert_field_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (field_id != $past(field_id) && !csync_n) |-> $fell(vsync_n));

endmodule

bind csync_gen csync_gen_chk #(.LW(LW), .MAX_LINES(MAX_LINES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .csync_n  (csync_n),
    .hsync_n  (hsync_n),
    .vsync_n  (vsync_n),
    .field_id (field_id),
    .line_num (line_num)
);

// File: tb/csync_gen_test.sv
module csync_gen_test;

    localparam int CLK_PERIOD = 10;
    localparam int PH = 20, PLS = 4, PEQ = 2, PBR = 16;
    localparam int NH = 18, NLS = 4, NEQ = 2, NBR = 14;
    localparam int HSW = 2;
    localparam int LWID = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            en = 1'b0;
    logic            std_ntsc = 1'b0;
    logic            interlace = 1'b1;
    logic            csync_n, hsync_n, vsync_n, field_id;
    logic [LWID-1:0] line_num;

    int nchk = 0;
    int nfail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    csync_gen #(
        .PAL_HALF(PH), .PAL_LSYNC(PLS), .PAL_EQ(PEQ), .PAL_BROAD(PBR),
        .NTSC_HALF(NH), .NTSC_LSYNC(NLS), .NTSC_EQ(NEQ), .NTSC_BROAD(NBR),
        .HS_W(HSW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .en(en), .std_ntsc(std_ntsc), .interlace(interlace),
        .csync_n(csync_n), .hsync_n(hsync_n), .vsync_n(vsync_n),
        .field_id(field_id), .line_num(line_num)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_idle(input string tag);
        chk({tag, " csync idle"}, int'(csync_n), 1);
        chk({tag, " hsync idle"}, int'(hsync_n), 1);
        chk({tag, " vsync idle"}, int'(vsync_n), 1);
        chk({tag, " field idle"}, int'(field_id), 0);
        chk({tag, " line idle"}, int'(line_num), 0);
    endtask

    // one full frame in the given mode; inputs switched to the next mode mid-frame
    task automatic run_frame(input bit ntsc, input bit il, input bit nx_ntsc,
                             input bit nx_il, input string mtag);
        int half, lsw, eqw, brw, lines, flen, total;
        half  = ntsc ? NH : PH;
        lsw   = ntsc ? NLS : PLS;
        eqw   = ntsc ? NEQ : PEQ;
        brw   = ntsc ? NBR : PBR;
        lines = ntsc ? 525 : 625;
        flen  = il ? lines : lines - 1;
        total = 2 * flen * half;
        for (int n = 0; n < total; n++) begin
            int hc, tk, h, fld, lowc;
            string ctag;
            @(posedge clk);
            @(negedge clk);
            hc  = n / half;
            tk  = n % half;
            fld = (hc >= flen) ? 1 : 0;
            h   = fld ? hc - flen : hc;
            if (h < 5 || (h >= 10 && h < 15)) lowc = (tk < eqw) ? 1 : 0;
            else if (h < 10)                  lowc = (tk < brw) ? 1 : 0;
            else                              lowc = (hc % 2 == 0 && tk < lsw) ? 1 : 0;
            ctag = (h < 15) ? "R4" : "R2";
            chk({ctag, " ", mtag, " csync"}, int'(csync_n), 1 - lowc);
            chk({"R5 ", mtag, " hsync"}, int'(hsync_n),
                (hc % 2 == 0 && tk < HSW) ? 0 : 1);
            chk({"R6 ", mtag, " vsync"}, int'(vsync_n), (h < 2) ? 0 : 1);
            chk({"R7 R3 ", mtag, " field"}, int'(field_id), fld);
            chk({"R8 ", mtag, " line"}, int'(line_num), hc / 2 + 1);
            if (n == 100) begin
                std_ntsc  = nx_ntsc;
                interlace = nx_il;
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk_idle("R1 reset");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk_idle("R1 disabled");
        en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk_idle("R1 first edge");
        // 625 interlaced, then 525 progressive, 625 progressive, 525 interlaced
        run_frame(1'b0, 1'b1, 1'b1, 1'b0, "R9 R3 pal-il");
        run_frame(1'b1, 1'b0, 1'b0, 1'b0, "R9 R10 ntsc-prog");
        run_frame(1'b0, 1'b0, 1'b1, 1'b1, "R9 R10 pal-prog");
        run_frame(1'b1, 1'b1, 1'b1, 1'b1, "R9 R10 ntsc-il");
        en = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        chk_idle("R1 after disable");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 195000);
        nchk++;
        nfail++;
        $display("FAIL watchdog R1-path run did not finish actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule